// File: doc/BRIEF.md
# Multi-Mode Histogram Accumulation Engine

This block is a clocked processing engine built around a single store of 1024 words, each 24 bits wide. A 3-bit function selector picks how incoming samples use that store. It can count occurrences of 10-bit sample values (a histogram), add 24-bit operands into bins, act as a writable lookup table, act as a 1024-sample delay line, output the difference between each sample and its delayed copy, or rewrite a stored histogram in place as a cumulative distribution.

The selector is latched on the rising edge of a load strobe. An active-low go signal then starts and stops the selected function on clock edges. While go is released, the engine answers lookup reads at the sample address, except in the two delay functions. A one-cycle wipe input empties the whole store and flushes the pipeline. Every update is a read-modify-write through a two-stage pipeline, and a one-deep bypass keeps back-to-back hits on the same word exact.

Top module: `histo_engine`

## Requirements
- R1: The result of a sample presented at clock edge k appears on `data_o` after edge k+2. `data_o` holds its value in any cycle that produces no result.
- R2: Selector code 0 (count) with `go_n` low adds one to the word addressed by `pixel_i`, and `data_o` shows the new count. Hits on the same word in consecutive cycles each count.
- R3: Selector code 1 (bin add) with `go_n` low adds `data_i` modulo 2^24 to the word addressed by `pixel_i`, and `data_o` shows the new sum.
- R4: Selector code 2 (table) with `go_n` low stores `data_i` at `pixel_i`, and `data_o` shows `data_i`. With `go_n` high and any selector except 3 and 4, `data_o` shows the word at `pixel_i`.
- R5: The selector is captured from `mode_sel` only on a clock edge where `mode_stb` is 1 and was 0 at the previous edge. It governs samples from the next edge on, and changes on `mode_sel` without a strobe have no effect.
- R6: Selector code 3 (delay) with `go_n` low writes `data_i` to successive words 0,1,…,1023 in a wrap-around sequence, and `data_o` shows the word's previous content. The sequence restarts at word 0 whenever `go_n` is sampled high.
- R7: Selector code 4 (delay difference) walks the store in the same way as R6, but `data_o` shows `data_i` minus the previous word content, modulo 2^24.
- R8: Selector code 5 (cumulative) with `go_n` low walks words 0 to 1023 once, in that order. Each word is replaced by the sum of itself and all lower words, and `data_o` shows each running sum. After word 1023 the walk stops until `go_n` has been high.
- R9: When `wipe` is sampled high, every word reads as 0 afterwards, `data_o` is 0 after that edge, and samples still in flight are dropped.
- R10: After `rst`, `data_o` is 0, every word reads as 0 and the selector is 7. Codes 6 and 7 do nothing while `go_n` is low.
- R11: With selector 3 or 4 and `go_n` high, no sample is processed and `data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wipe | input | 1 | Synchronous store and pipeline clear |
| mode_stb | input | 1 | Selector load strobe, captured on its rising level change |
| mode_sel | input | 3 | Function selector code |
| go_n | input | 1 | Active-low run control |
| pixel_i | input | 10 | Sample value used as word address |
| data_i | input | 24 | Operand or delay-line data |
| data_o | output | 24 | Registered result |

## Verification
A wrong word in the store stays hidden until that word is touched again. It then shows as a wrong count, sum or table value two edges after the touching sample, or as a wrong delayed value one full lap of 1024 samples later. A faulty bypass shows only when consecutive samples hit the same word: the second result comes out one short. A faulty walk counter in the cumulative function corrupts every later running sum, so a sweep of table reads after the walk reveals it across the whole store.

// File: rtl/histo_pkg.sv
package histo_pkg;
  typedef enum logic [2:0] {
    MD_COUNT = 3'd0,
    MD_BINADD = 3'd1,
    MD_TABLE = 3'd2,
    MD_DELAY = 3'd3,
    MD_DDIFF = 3'd4,
    MD_CUMUL = 3'd5,
    MD_NOP6 = 3'd6,
    MD_IDLE = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_INC,
    OP_ADD,
    OP_WR,
    OP_RD,
    OP_DLY,
    OP_DIFF,
    OP_CUM
  } op_e;
endpackage

// File: rtl/histo_ctl.sv
module histo_ctl
  import histo_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wipe,
  input  logic          mode_stb,
  input  logic [2:0]    mode_sel,
  input  logic          go_n,
  input  logic [AW-1:0] pixel_i,
  input  logic [DW-1:0] data_i,
  output op_e           s1_op,
  output logic [AW-1:0] s1_addr,
  output logic [DW-1:0] s1_data,
  output logic          s1_first
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  mode_e         mode_q;
  logic          stb_q;
  logic [AW-1:0] walk_q;
  logic          done_q;
  op_e           op_c;
  logic [AW-1:0] addr_c;

  always_comb begin
    op_c   = OP_NONE;
    addr_c = pixel_i;
    if (go_n) begin
      if (mode_q != MD_DELAY && mode_q != MD_DDIFF) op_c = OP_RD;
    end else begin
      case (mode_q)
        MD_COUNT:  op_c = OP_INC;
        MD_BINADD: op_c = OP_ADD;
        MD_TABLE:  op_c = OP_WR;
        MD_DELAY:  begin op_c = OP_DLY;  addr_c = walk_q; end
        MD_DDIFF:  begin op_c = OP_DIFF; addr_c = walk_q; end
        MD_CUMUL:  if (!done_q) begin op_c = OP_CUM; addr_c = walk_q; end
        default:   op_c = OP_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_IDLE;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= mode_stb;
      if (mode_stb && !stb_q) mode_q <= mode_e'(mode_sel);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      walk_q   <= '0;
      done_q   <= 1'b0;
      s1_op    <= OP_NONE;
      s1_addr  <= '0;
      s1_data  <= '0;
      s1_first <= 1'b0;
    end else begin
      s1_op    <= op_c;
      s1_addr  <= addr_c;
      s1_data  <= data_i;
      s1_first <= (walk_q == '0);
      if (go_n) begin
        walk_q <= '0;
        done_q <= 1'b0;
      end else if (op_c == OP_DLY || op_c == OP_DIFF) begin
        walk_q <= walk_q + 1'b1;
      end else if (op_c == OP_CUM) begin
        walk_q <= walk_q + 1'b1;
        if (walk_q == LAST) done_q <= 1'b1;
      end
    end
  end

  // R5: selector moves only after a strobe rising edge
  assert_mode_on_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |-> $past(mode_stb && !stb_q));
  // R6: released go restarts the walk at word 0
  assert_walk_restart_R6: assert property (@(posedge clk) disable iff (rst)
    go_n |=> (walk_q == '0));
  // R8: a finished cumulative walk has wrapped to word 0
  assert_walk_done_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (walk_q == '0));
endmodule

// File: rtl/histo_store.sv
module histo_store #(
  parameter int AW = 10,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wipe,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] live_q;
  logic [DW-1:0]    rd_q;
  logic             rd_live_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      live_q    <= '0;
      rd_live_q <= 1'b0;
    end else begin
      if (wr_en) live_q[wr_addr] <= 1'b1;
      rd_live_q <= live_q[rd_addr];
    end
  end

  assign rd_data = rd_live_q ? rd_q : '0;

  // R9: a wipe leaves no word marked as holding data
  assert_wipe_empties_R9: assert property (@(posedge clk) disable iff (rst)
    $past(wipe) |-> (live_q == '0));
endmodule

// File: rtl/histo_dpath.sv
module histo_dpath
  import histo_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wipe,
  input  op_e           s1_op,
  input  logic [AW-1:0] s1_addr,
  input  logic [DW-1:0] s1_data,
  input  logic          s1_first,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] data_o
);
  op_e           s2_op;
  logic [AW-1:0] s2_addr;
  logic [DW-1:0] s2_data;
  logic          s2_first;
  logic          fw_v;
  logic [AW-1:0] fw_addr;
  logic [DW-1:0] fw_val;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] base, nval, outv;
  logic          we_c, oe_c;

  always_comb begin
    base = (fw_v && fw_addr == s2_addr) ? fw_val : rd_data;
    nval = s2_data;
    outv = s2_data;
    we_c = 1'b1;
    oe_c = 1'b1;
    case (s2_op)
      OP_INC:  begin nval = base + 1'b1;    outv = nval; end
      OP_ADD:  begin nval = base + s2_data; outv = nval; end
      OP_WR:   outv = s2_data;
      OP_RD:   begin we_c = 1'b0; outv = base; end
      OP_DLY:  outv = base;
      OP_DIFF: outv = s2_data - base;
      OP_CUM:  begin nval = base + (s2_first ? '0 : acc_q); outv = nval; end
      default: begin we_c = 1'b0; oe_c = 1'b0; end
    endcase
  end

  assign wr_en   = we_c && !wipe && !rst;
  assign wr_addr = s2_addr;
  assign wr_data = nval;

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      s2_op    <= OP_NONE;
      s2_addr  <= '0;
      s2_data  <= '0;
      s2_first <= 1'b0;
      fw_v     <= 1'b0;
      fw_addr  <= '0;
      fw_val   <= '0;
      acc_q    <= '0;
      data_o   <= '0;
    end else begin
      s2_op    <= s1_op;
      s2_addr  <= s1_addr;
      s2_data  <= s1_data;
      s2_first <= s1_first;
      fw_v     <= we_c;
      fw_addr  <= s2_addr;
      fw_val   <= nval;
      if (s2_op == OP_CUM) acc_q <= nval;
      if (oe_c) data_o <= outv;
    end
  end

  // R9: output is zero right after a wipe
  assert_wipe_output_R9: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (data_o == '0));
  // R2: a count result is never zero
  assert_count_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    (s2_op == OP_INC && !wipe) |=> (data_o != '0));
  // R11: with no operation in the last stage the output holds
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (s2_op == OP_NONE && !wipe) |=> $stable(data_o));
endmodule

// File: rtl/histo_engine.sv
module histo_engine
  import histo_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wipe,
  input  logic          mode_stb,
  input  logic [2:0]    mode_sel,
  input  logic          go_n,
  input  logic [AW-1:0] pixel_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);
  op_e           s1_op;
  logic [AW-1:0] s1_addr;
  logic [DW-1:0] s1_data;
  logic          s1_first;
  logic [DW-1:0] rd_data;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  histo_ctl #(.AW(AW), .DW(DW)) u_ctl (
    .clk(clk), .rst(rst), .wipe(wipe), .mode_stb(mode_stb),
    .mode_sel(mode_sel), .go_n(go_n), .pixel_i(pixel_i), .data_i(data_i),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_data(s1_data), .s1_first(s1_first)
  );

  histo_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .wipe(wipe), .rd_addr(s1_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  histo_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rst(rst), .wipe(wipe), .s1_op(s1_op), .s1_addr(s1_addr),
    .s1_data(s1_data), .s1_first(s1_first), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .data_o(data_o)
  );

  // R10: reset leaves the output at zero
  assert_reset_output_R10: assert property (@(posedge clk)
    rst |=> (data_o == '0));
endmodule

// File: tb/sim_histo_engine.sv
module sim_histo_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wipe = 1'b0;
  logic        mode_stb = 1'b0;
  logic [2:0]  mode_sel = 3'd7;
  logic        go_n = 1'b1;
  logic [9:0]  pixel_i = '0;
  logic [23:0] data_i = '0;
  logic [23:0] data_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [23:0] mm [1024];
  int          m_mode = 7;
  bit          m_stb_prev = 0;
  int          m_cnt = 0;
  bit          m_done = 0;
  logic [23:0] m_run = '0;
  logic [23:0] last_exp = '0;
  bit          sh_v [3];
  logic [23:0] sh_e [3];
  string       sh_t [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  histo_engine u0 (
    .clk(clk), .rst(rst), .wipe(wipe), .mode_stb(mode_stb), .mode_sel(mode_sel),
    .go_n(go_n), .pixel_i(pixel_i), .data_i(data_i), .data_o(data_o)
  );

  task automatic check(input logic [23:0] exp, input string tag);
    tests++;
    if (data_o !== exp) begin
      fails++;
      $display("FAIL %s: data_o=%0h expected %0h", tag, data_o, exp);
    end
  endtask

  function automatic logic [23:0] model(input logic [9:0] p, input logic [23:0] d, input bit sn);
    logic [23:0] e;
    e = last_exp;
    if (sn) begin
      if (m_mode != 3 && m_mode != 4) e = mm[p];
      m_cnt = 0;
      m_done = 0;
    end else begin
      case (m_mode)
        0: begin mm[p] = mm[p] + 24'd1; e = mm[p]; end
        1: begin mm[p] = mm[p] + d; e = mm[p]; end
        2: begin mm[p] = d; e = d; end
        3: begin e = mm[m_cnt]; mm[m_cnt] = d; m_cnt = (m_cnt + 1) % 1024; end
        4: begin e = d - mm[m_cnt]; mm[m_cnt] = d; m_cnt = (m_cnt + 1) % 1024; end
        5: if (!m_done) begin
             m_run = ((m_cnt == 0) ? 24'd0 : m_run) + mm[m_cnt];
             mm[m_cnt] = m_run;
             e = m_run;
             if (m_cnt == 1023) m_done = 1;
             m_cnt = (m_cnt + 1) % 1024;
           end
        default: ;
      endcase
    end
    return e;
  endfunction

  // one clock: check the oldest pending result, update model, drive inputs
  task automatic step(input logic [9:0] p, input logic [23:0] d, input bit sn,
                      input bit ld, input bit fc, input string tag);
    @(negedge clk);
    if (sh_v[2]) check(sh_e[2], sh_t[2]);
    sh_v[2] = sh_v[1]; sh_e[2] = sh_e[1]; sh_t[2] = sh_t[1];
    sh_v[1] = sh_v[0]; sh_e[1] = sh_e[0]; sh_t[1] = sh_t[0];
    if (fc) begin
      for (int i = 0; i < 1024; i++) mm[i] = '0;
      m_cnt = 0; m_done = 0; last_exp = '0;
      for (int i = 0; i < 3; i++) begin sh_v[i] = 1; sh_e[i] = '0; sh_t[i] = tag; end
    end else begin
      last_exp = model(p, d, sn);
      sh_v[0] = 1; sh_e[0] = last_exp; sh_t[0] = tag;
    end
    if (ld && !m_stb_prev) m_mode = int'(mode_sel);
    m_stb_prev = ld;
    pixel_i = p; data_i = d; go_n = sn; mode_stb = ld; wipe = fc;
  endtask

  task automatic load_mode(input logic [2:0] code, input string tag);
    mode_sel = code;
    step(10'd0, 24'd0, 1, 1, 0, tag);
    step(10'd0, 24'd0, 1, 0, 0, tag);
    step(10'd0, 24'd0, 1, 0, 0, tag);
  endtask

  task automatic read_range(input int lo, input int hi, input string tag);
    for (int a = lo; a <= hi; a++) step(10'(a), 24'd0, 1, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) mm[i] = '0;
    for (int i = 0; i < 3; i++) begin sh_v[i] = 0; sh_e[i] = '0; sh_t[i] = ""; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(24'd0, "R10 reset output");
    // R10: idle selector does nothing with go low, reads zero with go high
    for (int i = 0; i < 5; i++) step(10'($urandom_range(0, 1023)), 24'h5, 0, 0, 0, "R10");
    for (int i = 0; i < 8; i++) step(10'($urandom_range(0, 1023)), 24'h0, 1, 0, 0, "R10");
    // R2: counting with narrow range, plus a directed same-bin run
    load_mode(3'd0, "R5");
    for (int i = 0; i < 400; i++) step(10'($urandom_range(0, 15)), 24'h0, 0, 0, 0, "R2");
    for (int i = 0; i < 6; i++) step(10'd5, 24'h0, 0, 0, 0, "R2");
    // R5: selector changes without a strobe are ignored
    mode_sel = 3'd1;
    for (int i = 0; i < 20; i++) step(10'($urandom_range(0, 15)), 24'h123, 0, 0, 0, "R5");
    read_range(0, 15, "R2");
    // R3: bin add with repeated bins
    load_mode(3'd1, "R5");
    for (int i = 0; i < 300; i++) begin
      logic [9:0] p = 10'($urandom_range(100, 131));
      step(p, 24'($urandom_range(0, 65535)), 0, 0, 0, "R3");
      if (i % 37 == 0) step(p, 24'hFFFFFF, 0, 0, 0, "R3");
    end
    read_range(100, 131, "R3");
    // R4: table writes and reads, R1: read right after write
    load_mode(3'd2, "R5");
    for (int i = 0; i < 64; i++) step(10'($urandom_range(200, 263)), 24'($urandom), 0, 0, 0, "R4");
    step(10'd300, 24'hABCDEF, 0, 0, 0, "R1");
    step(10'd300, 24'h0, 1, 0, 0, "R1");
    read_range(200, 263, "R4");
    // R6 and R11: delay line over more than one lap
    load_mode(3'd3, "R5");
    for (int i = 0; i < 1100; i++) step(10'd0, 24'($urandom), 0, 0, 0, "R6");
    for (int i = 0; i < 6; i++) step(10'($urandom_range(0, 1023)), 24'h1, 1, 0, 0, "R11");
    // R7: delay difference
    load_mode(3'd4, "R5");
    for (int i = 0; i < 1100; i++) step(10'd0, 24'($urandom), 0, 0, 0, "R7");
    for (int i = 0; i < 4; i++) step(10'd7, 24'h2, 1, 0, 0, "R11");
    // R8: fill a histogram, then the cumulative walk
    load_mode(3'd2, "R5");
    for (int a = 0; a < 1024; a++) step(10'(a), 24'($urandom_range(0, 300)), 0, 0, 0, "R4");
    load_mode(3'd5, "R5");
    for (int i = 0; i < 1030; i++) step(10'd0, 24'h0, 0, 0, 0, "R8");
    read_range(0, 1023, "R8");
    // R9: wipe in the middle of counting
    load_mode(3'd0, "R5");
    for (int i = 0; i < 20; i++) step(10'($urandom_range(0, 7)), 24'h0, 0, 0, 0, "R2");
    step(10'd3, 24'h0, 0, 0, 1, "R9");
    for (int i = 0; i < 5; i++) step(10'd4, 24'h0, 0, 0, 0, "R9");
    read_range(0, 7, "R9");
    read_range(1000, 1023, "R9");
    for (int i = 0; i < 4; i++) step(10'd0, 24'h0, 1, 0, 0, "R1");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule